// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between a clock synthesizer and its output pads. It gates two clocks. One is the spread-spectrum main clock from the PLL. The other is a free-running, non-spread reference clock. The block takes three kinds of control: an asynchronous active-low power-down pin, one enable bit per output from the register file, and a register bit that selects the pad state while the outputs are stopped. That pad state is either high impedance or driven low.

Each output has a gate cell in its own clock domain. The cell takes its control inputs through a synchronizer and updates the gate only on the falling clock edge. A clock therefore stops only after a complete high phase and restarts only with a complete high phase.

The power-down sequencer runs on the reference clock. It first waits until both gates report closed, and only then asks the PLL and VCO to power down. When power-down is released, the sequencer holds the outputs stopped for a stabilization interval set by a parameter, then lets them run again. If power-down returns during that interval, the count starts over from zero. The interval is `STABLE_CYCLES` reference periods. The integrator chooses the parameter so that this stays at or below 3 ms.

Top module: `clk_stop_ctrl`

## Requirements
- R1: Once the synchronized `pwr_dn_n` is low, both gated outputs stop and stay low. `pll_pd_req` rises only after both gate cells report closed.
- R2: `pll_pd_req` is 1 only in the powered-down state. It is 0 while the clocks run and 0 during the stabilization wait after release.
- R3: Every high pulse on `main_clk_out` or `ref_clk_out` lasts exactly one full high phase of its source clock. Every low gap lasts at least one low phase. This holds across enable changes, power-down entry and restart.
- R4: A gate changes state only on the falling edge of its clock. If its synchronized request is low at a falling edge, the next high phase is suppressed. If the request is high, the next high phase is passed.
- R5: While the outputs are stopped by power-down, or are waiting out stabilization, `clk_oe` is 0 when `pd_drive_low` is 0 and 1 when `pd_drive_low` is 1. `clk_oe` is 1 while the clocks run.
- R6: After `pwr_dn_n` rises, both outputs stay stopped for at least `STABLE_CYCLES` reference cycles. They resume within a few cycles after that.
- R7: If `pwr_dn_n` falls again during the stabilization wait, the sequencer returns to power-down. The full interval is then counted again from the next release.
- R8: With `main_en` = 0, `main_clk_out` is held low while `ref_clk_out` keeps toggling. With `ref_en` = 0, `ref_clk_out` is held low while `main_clk_out` keeps toggling. Setting the bit back to 1 resumes that output.
- R9: Enable bits and run permission pass through `SYNC_STAGES` flops in each output's clock domain. When a bit rises just after a rising edge, the first passed high phase begins on the (`SYNC_STAGES`+1)-th rising edge of that clock.
- R10: During reset, both outputs and `pll_pd_req` are 0. After reset the sequencer is in the stabilization wait, so the clocks start only after the interval of R6.
- R11: The stabilization counter never reaches `STABLE_CYCLES`. It is cleared whenever it leaves the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_in | input | 1 | Spread-spectrum clock from the PLL |
| clk_ref_in | input | 1 | Free-running reference clock; also clocks the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down request |
| main_en | input | 1 | Register bit: 1 lets the main clock run |
| ref_en | input | 1 | Register bit: 1 lets the reference clock run |
| pd_drive_low | input | 1 | Register bit: 1 drives stopped outputs low, 0 three-states them |
| main_clk_out | output | 1 | Gated main clock |
| ref_clk_out | output | 1 | Gated reference clock |
| clk_oe | output | 1 | Pad output enable for both clock outputs |
| pll_pd_req | output | 1 | Request to power down the PLL and VCO |

## Verification
The assertions assume that both source clocks keep toggling for the whole run, including power-down, so that the gate cells can report closed. They also assume that the register bits and the power-down pin are asynchronous levels that stay put for at least a few cycles of the slower clock.

The stimulus keeps both clocks free-running at fixed, unrelated periods. It holds each power-down pulse for at least four reference cycles. It changes the enable bits only between clock edges, and some of those changes come deliberately in rapid succession, to test how the gates behave at their edges.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Sequencer states, reference-clock domain
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_DOWN = 2'd2,
        ST_WAIT = 2'd3
    } seq_state_e;

    // Helper for counter width
    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d;
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en_async,
    input  logic allow_async,
    output logic clk_gated,
    output logic closed
);

    logic [1:0] req_s;
    logic       en_s;
    logic       allow_s;

    // Both controls synchronized separately, then combined in this domain
    clkstop_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) i_req_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .din   ({allow_async, en_async}),
        .dout  (req_s)
    );

    assign en_s    = req_s[0];
    assign allow_s = req_s[1];

    logic gate_d;
    logic gate_q;

    always_comb begin
        gate_d = en_s & allow_s;
    end

    // Falling-edge register: gate moves only while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign clk_gated = clk_src & gate_q;
    assign closed    = ~gate_q;

    // R4
    stop_after_high_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        !(en_s && allow_s) |=> !clk_gated);

    // R3
    start_full_high_chk: assert property (@(negedge clk_src) disable iff (!rst_n)
        (en_s && allow_s) |=> clk_gated);

endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int STABLE_CYCLES = 40000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn_n,
    input  logic [1:0] gate_closed,
    input  logic       pd_drive_low,
    output logic       run_allow,
    output logic       oe,
    output logic       pll_req
);

    localparam int CNT_W = cnt_width(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             oe;
        logic             pll;
    } seq_regs_t;

    logic       pd_n_s;
    logic [1:0] closed_s;

    clkstop_sync #(
        .WIDTH   (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pwr_dn_n),
        .dout  (pd_n_s)
    );

    clkstop_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_closed_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gate_closed),
        .dout  (closed_s)
    );

    seq_regs_t r_d;
    seq_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                if (!pd_n_s) r_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (closed_s == 2'b11) r_d.state = ST_DOWN;
            end
            ST_DOWN: begin
                r_d.cnt = '0;
                if (pd_n_s) r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!pd_n_s) begin
                    r_d.state = ST_DOWN;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == CNT_LAST) begin
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_WAIT;
        endcase
        r_d.run = (r_d.state == ST_RUN);
        r_d.pll = (r_d.state == ST_DOWN);
        r_d.oe  = (r_d.state == ST_RUN) || (r_d.state == ST_STOP) || pd_drive_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_WAIT;
            r_q.cnt   <= '0;
            r_q.run   <= 1'b0;
            r_q.oe    <= 1'b0;
            r_q.pll   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_allow = r_q.run;
    assign oe        = r_q.oe;
    assign pll_req   = r_q.pll;

    // R1
    pll_req_after_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pll |-> (closed_s == 2'b11));

    // R1
    run_drops_on_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n_s |=> !r_q.run);

    // R5
    hiz_only_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.oe |-> !r_q.run);

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CNT_W'(STABLE_CYCLES));

    // R2
    pll_not_while_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.pll && r_q.run));

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
    parameter int STABLE_CYCLES = 40000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_main_in,
    input  logic clk_ref_in,
    input  logic rst_n,
    input  logic pwr_dn_n,
    input  logic main_en,
    input  logic ref_en,
    input  logic pd_drive_low,
    output logic main_clk_out,
    output logic ref_clk_out,
    output logic clk_oe,
    output logic pll_pd_req
);

    localparam int N_OUT = 2;

    logic [N_OUT-1:0] src_clk;
    logic [N_OUT-1:0] en_bits;
    logic [N_OUT-1:0] gated;
    logic [N_OUT-1:0] closed;
    logic             run_allow;

    assign src_clk = {clk_ref_in, clk_main_in};
    assign en_bits = {ref_en, main_en};

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        clkstop_gate #(
            .SYNC_STAGES (SYNC_STAGES)
        ) i_gate (
            .clk_src     (src_clk[g]),
            .rst_n       (rst_n),
            .en_async    (en_bits[g]),
            .allow_async (run_allow),
            .clk_gated   (gated[g]),
            .closed      (closed[g])
        );
    end

    clkstop_seq #(
        .STABLE_CYCLES (STABLE_CYCLES),
        .SYNC_STAGES   (SYNC_STAGES)
    ) i_seq (
        .clk          (clk_ref_in),
        .rst_n        (rst_n),
        .pwr_dn_n     (pwr_dn_n),
        .gate_closed  (closed),
        .pd_drive_low (pd_drive_low),
        .run_allow    (run_allow),
        .oe           (clk_oe),
        .pll_req      (pll_pd_req)
    );

    assign main_clk_out = gated[0];
    assign ref_clk_out  = gated[1];

endmodule

// File: tb/test_clk_stop_ctrl.sv
`timescale 1ns/1ps
module test_clk_stop_ctrl;

    localparam int CLK_PERIOD  = 20;   // reference clock
    localparam int MAIN_PERIOD = 14;   // main clock
    localparam int STABLE      = 40;
    localparam int SYNC        = 2;

    logic clk_main_in = 1'b0;
    logic clk_ref_in  = 1'b0;
    logic rst_n       = 1'b0;
    logic pwr_dn_n    = 1'b1;
    logic main_en     = 1'b1;
    logic ref_en      = 1'b1;
    logic pd_drive_low = 1'b0;
    logic main_clk_out, ref_clk_out, clk_oe, pll_pd_req;

    int n_checks = 0;
    int n_fail   = 0;
    int runts    = 0;
    bit done     = 0;

    always #(MAIN_PERIOD/2) clk_main_in = ~clk_main_in;
    always #(CLK_PERIOD/2)  clk_ref_in  = ~clk_ref_in;

    clk_stop_ctrl #(
        .STABLE_CYCLES (STABLE),
        .SYNC_STAGES   (SYNC)
    ) i_clk_stop_ctrl (
        .clk_main_in  (clk_main_in),
        .clk_ref_in   (clk_ref_in),
        .rst_n        (rst_n),
        .pwr_dn_n     (pwr_dn_n),
        .main_en      (main_en),
        .ref_en       (ref_en),
        .pd_drive_low (pd_drive_low),
        .main_clk_out (main_clk_out),
        .ref_clk_out  (ref_clk_out),
        .clk_oe       (clk_oe),
        .pll_pd_req   (pll_pd_req)
    );

    // Pulse-width monitors for R3
    longint m_rise = -1, m_fall = -1, r_rise = -1, r_fall = -1;
    always @(posedge main_clk_out) begin
        if (m_fall >= 0 && ($time - m_fall) < MAIN_PERIOD/2) runts++;
        m_rise = $time;
    end
    always @(negedge main_clk_out) begin
        if (m_rise >= 0 && ($time - m_rise) != MAIN_PERIOD/2) runts++;
        m_fall = $time;
    end
    always @(posedge ref_clk_out) begin
        if (r_fall >= 0 && ($time - r_fall) < CLK_PERIOD/2) runts++;
        r_rise = $time;
    end
    always @(negedge ref_clk_out) begin
        if (r_rise >= 0 && ($time - r_rise) != CLK_PERIOD/2) runts++;
        r_fall = $time;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ref_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_ref_in);
        #1;
    endtask

    // Reference cycles from now until ref_clk_out is first seen high
    task automatic wait_ref_start(output int cyc);
        cyc = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk_ref_in); #1;
            cyc++;
            if (ref_clk_out) break;
        end
    endtask

    task automatic count_high(input bit use_main, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (use_main) begin @(posedge clk_main_in); #1; if (main_clk_out) highs++; end
            else begin @(posedge clk_ref_in); #1; if (ref_clk_out) highs++; end
        end
    endtask

    task automatic t_reset;
        int cyc;
        ref_cycles(5);
        check(main_clk_out == 0 && ref_clk_out == 0, "R10 outputs low in reset", main_clk_out + ref_clk_out, 0);
        check(pll_pd_req == 0, "R10 pll_pd_req low in reset", pll_pd_req, 0);
        check(clk_oe == 0, "R5 oe low while stopped, drive_low=0", clk_oe, 0);
        @(negedge clk_ref_in); rst_n = 1'b1;
        wait_ref_start(cyc);
        check(cyc >= STABLE && cyc <= STABLE + 10, "R10 start delay after reset", cyc, STABLE);
        check(clk_oe == 1, "R5 oe high while running", clk_oe, 1);
    endtask

    task automatic t_power_down(input bit drive_low);
        int h, cyc;
        pd_drive_low = drive_low;
        @(negedge clk_ref_in); pwr_dn_n = 1'b0;
        ref_cycles(15);
        check(pll_pd_req == 1, "R2 pll_pd_req high in power-down", pll_pd_req, 1);
        check(clk_oe == drive_low, "R5 oe follows drive-low bit in power-down", clk_oe, drive_low);
        count_high(1, 20, h);
        check(h == 0, "R1 main stopped in power-down", h, 0);
        count_high(0, 20, h);
        check(h == 0, "R1 ref stopped in power-down", h, 0);
        @(negedge clk_ref_in); pwr_dn_n = 1'b1;
        ref_cycles(6);
        check(pll_pd_req == 0, "R2 pll_pd_req low during wait", pll_pd_req, 0);
        check(clk_oe == drive_low, "R5 oe during stabilization wait", clk_oe, drive_low);
        wait_ref_start(cyc);
        cyc += 6;
        check(cyc >= STABLE && cyc <= STABLE + 12, "R6 restart after stabilization", cyc, STABLE);
        check(clk_oe == 1, "R5 oe high after restart", clk_oe, 1);
        pd_drive_low = 1'b0;
    endtask

    task automatic t_restart_timer;
        int h, cyc;
        @(negedge clk_ref_in); pwr_dn_n = 1'b0;
        ref_cycles(15);
        @(negedge clk_ref_in); pwr_dn_n = 1'b1;
        ref_cycles(STABLE / 2);
        count_high(0, 1, h);
        check(h == 0 && ref_clk_out == 0, "R7 still stopped mid-wait", h, 0);
        @(negedge clk_ref_in); pwr_dn_n = 1'b0;
        ref_cycles(5);
        check(pll_pd_req == 1, "R7 back to power-down during wait", pll_pd_req, 1);
        @(negedge clk_ref_in); pwr_dn_n = 1'b1;
        wait_ref_start(cyc);
        check(cyc >= STABLE && cyc <= STABLE + 10, "R7 full interval after re-release", cyc, STABLE);
    endtask

    task automatic t_enables;
        int h, cyc;
        @(posedge clk_main_in); #1; main_en = 1'b0;
        ref_cycles(10);
        count_high(1, 20, h);
        check(h == 0, "R8 main held low when disabled", h, 0);
        count_high(0, 20, h);
        check(h == 20, "R8 ref keeps running", h, 20);
        @(posedge clk_main_in); #1; main_en = 1'b1;
        cyc = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk_main_in); #1; cyc++;
            if (main_clk_out) break;
        end
        check(cyc == SYNC + 1, "R9 main enable latency", cyc, SYNC + 1);
        @(posedge clk_ref_in); #1; ref_en = 1'b0;
        ref_cycles(8);
        count_high(0, 20, h);
        check(h == 0, "R8 ref held low when disabled", h, 0);
        count_high(1, 20, h);
        check(h == 20, "R8 main keeps running", h, 20);
        @(posedge clk_ref_in); #1; ref_en = 1'b1;
        cyc = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk_ref_in); #1; cyc++;
            if (ref_clk_out) break;
        end
        check(cyc == SYNC + 1, "R9 ref enable latency", cyc, SYNC + 1);
    endtask

    task automatic t_enable_churn;
        for (int i = 0; i < 60; i++) begin
            #((i * 7) % 23 + 3);
            main_en = ~main_en;
            if (i % 3 == 0) ref_en = ~ref_en;
        end
        main_en = 1'b1;
        ref_en  = 1'b1;
        ref_cycles(10);
        check(runts == 0, "R3 no runt or shortened pulses", runts, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_power_down(1'b0);
        t_power_down(1'b1);
        t_restart_timer();
        t_enables();
        t_enable_churn();
        check(runts == 0, "R3 pulse widths over whole run", runts, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule